// File: doc/BRIEF.md
# Bus Fault Pattern Probe

This block checks a byte-wide memory with a 22-bit address for broken address or data connections. It defines an expected byte for every address and can be asked for that byte at any time through a combinational lookup port. The map is built so that a single stuck or open line gives a read value that points straight at the line. The two probe locations, address zero and the all-ones address, hold bytes that are complements of each other. Each location one address bit away from a probe holds a code that names that bit. Every other location holds one of six bytes, picked by the number of ones in its address.

While enabled, the block issues reads to the memory that alternate between the bottom and the top address. Every address line and every data line therefore changes on every read. It compares each returned byte with the expected byte and sorts any mismatch into one of four classes: a single data line, an address line, a two-bit error, or unexplained. Each mismatch is offered on a result port with valid/ready handshake. Counters keep the number of reads and the number of faults in each class, and a start pulse clears them.

Writing and erasing the memory is left to other logic. This block only reads and checks.

Top module: `bus_fault_probe`

## Requirements
- R1: After reset, `mem_req` and `res_valid` are low and all five counters are zero.
- R2: The lookup port returns 0xFF for address 0 and 0x00 for the all-ones address.
- R3: For bit k (k from 0 to 21), the addresses with only bit k set and with only bit k clear both return code k. The codes in order of k are 07,0B,0D,0E,16,1A,1C,1F,25,29,2C,2F,34,38,3D,3E,43,49,4A,4F,52,58.
- R4: Any other address returns a byte from the ring 33,55,66,99,AA,CC, indexed from 0 by the number of ones in the address modulo 6.
- R5: While `run_en` is high, the block issues reads as one-cycle `mem_req` pulses. The first read after reset or start goes to address 0, and after that reads alternate between 0 and all-ones. Only one read is outstanding at a time, and no read is issued while a result waits.
- R6: A response equal to the expected byte produces no result. Class codes on `res_class`: 1 data line, 2 address line, 3 double, 4 unexplained. Code 0 never appears with `res_valid`.
- R7: A response that differs in exactly one bit, and is not a pin code, gives class 1 with `res_pin` set to the differing bit position.
- R8: A response that equals code k gives class 2 with `res_pin` = k. This test takes priority over the bit-count tests.
- R9: Any other mismatch gives class 3 if exactly two bits differ, or class 4 if more bits differ. In both cases `res_pin` is 0.
- R10: A result carries the address, expected byte and actual byte. It stays unchanged and valid until `res_ready` is sampled high.
- R11: `cnt_reads` counts every response. `cnt_data`, `cnt_addr`, `cnt_double` and `cnt_unexpl` count responses of classes 1 to 4.
- R12: A `start` pulse zeroes all counters, drops a waiting result, and makes the next read go to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears counters and pending result, restarts at bottom |
| run_en | input | 1 | Enables the alternating read sequence |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read address, held until the next request |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | DATA_W | Read response byte |
| res_valid | output | 1 | A fault result is waiting |
| res_ready | input | 1 | Consumer accepts the result |
| res_addr | output | ADDR_W | Address of the faulty read |
| res_exp | output | DATA_W | Expected byte |
| res_act | output | DATA_W | Byte actually returned |
| res_class | output | 3 | Fault class code |
| res_pin | output | PIN_W | Data bit or address pin index |
| q_addr | input | ADDR_W | Lookup address |
| q_data | output | DATA_W | Expected byte for `q_addr` |
| cnt_reads | output | CNT_W | Responses since start |
| cnt_data | output | CNT_W | Single data-line faults |
| cnt_addr | output | CNT_W | Address-line faults |
| cnt_double | output | CNT_W | Two-bit faults |
| cnt_unexpl | output | CNT_W | Unexplained faults |

## Verification
The probe only ever reads two addresses, so the 44 pin-code locations can be reached only through a faulty address path. The bench memory XORs a chosen address line into every request before it looks up the stored byte, so each of the 22 pins is exercised from both probes. Data faults are injected by XOR on the returned byte. Some of these masks, such as three low bits flipped from 0x00, land exactly on a pin code, and they test the priority of the address-line class. The other hard case is a start pulse that arrives while a result is held under back-pressure. The bench reaches it by keeping `res_ready` low after a single faulty read.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

   localparam int BFC_MAX_ADDR_W = 22;
   localparam int BFC_RING_LEN   = 6;
   localparam int BFC_NUM_CNT    = 5;

   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_DATA   = 3'd1,
      CLS_ADDR   = 3'd2,
      CLS_DOUBLE = 3'd3,
      CLS_UNEXPL = 3'd4
   } bfc_class_e;

   // Byte naming address pin k; pairwise >= 2 bits apart, >= 3 bits from 00/FF
   function automatic logic [7:0] bfc_pin_code(input int k);
      case (k)
         0:  return 8'h07;
         1:  return 8'h0B;
         2:  return 8'h0D;
         3:  return 8'h0E;
         4:  return 8'h16;
         5:  return 8'h1A;
         6:  return 8'h1C;
         7:  return 8'h1F;
         8:  return 8'h25;
         9:  return 8'h29;
         10: return 8'h2C;
         11: return 8'h2F;
         12: return 8'h34;
         13: return 8'h38;
         14: return 8'h3D;
         15: return 8'h3E;
         16: return 8'h43;
         17: return 8'h49;
         18: return 8'h4A;
         19: return 8'h4F;
         20: return 8'h52;
         21: return 8'h58;
         default: return 8'h00;
      endcase
   endfunction

   // Filler bytes for all locations away from the probes
   function automatic logic [7:0] bfc_ring_byte(input int idx);
      case (idx)
         0: return 8'h33;
         1: return 8'h55;
         2: return 8'h66;
         3: return 8'h99;
         4: return 8'hAA;
         5: return 8'hCC;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/bfc_expect.sv
module bfc_expect
   import bfc_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   localparam int ONES_W = $clog2(ADDR_W + 1);
   localparam int IDX_W  = $clog2(ADDR_W);

   logic [ONES_W-1:0] ones;
   logic [IDX_W-1:0]  set_idx;
   logic [IDX_W-1:0]  clr_idx;

   always_comb begin
      ones    = '0;
      set_idx = '0;
      clr_idx = '0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (addr[i]) begin
            ones    = ones + ONES_W'(1);
            set_idx = IDX_W'(i);
         end else begin
            clr_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (ones == '0) begin
         data = '1;
      end else if (ones == ONES_W'(ADDR_W)) begin
         data = '0;
      end else if (ones == ONES_W'(1)) begin
         data = DATA_W'(bfc_pin_code(int'(set_idx)));
      end else if (ones == ONES_W'(ADDR_W - 1)) begin
         data = DATA_W'(bfc_pin_code(int'(clr_idx)));
      end else begin
         data = DATA_W'(bfc_ring_byte(int'(ones) % BFC_RING_LEN));
      end
   end

endmodule

// File: rtl/bfc_classify.sv
module bfc_classify
   import bfc_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 8,
   parameter int PIN_W  = 5
) (
   input  logic [DATA_W-1:0] exp_byte,
   input  logic [DATA_W-1:0] act_byte,
   output bfc_class_e        cls,
   output logic [PIN_W-1:0]  pin
);

   localparam int NDIFF_W = $clog2(DATA_W + 1);

   logic [ADDR_W-1:0]  code_hit;
   logic [DATA_W-1:0]  diff;
   logic [NDIFF_W-1:0] ndiff;
   logic [PIN_W-1:0]   hit_idx;
   logic [PIN_W-1:0]   bit_idx;

   for (genvar g = 0; g < ADDR_W; g++) begin : g_code
      assign code_hit[g] = (act_byte == DATA_W'(bfc_pin_code(g)));
   end

   assign diff = exp_byte ^ act_byte;

   always_comb begin
      hit_idx = '0;
      for (int i = ADDR_W - 1; i >= 0; i--) begin
         if (code_hit[i]) hit_idx = PIN_W'(i);
      end
   end

   always_comb begin
      ndiff   = '0;
      bit_idx = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (diff[i]) begin
            ndiff   = ndiff + NDIFF_W'(1);
            bit_idx = PIN_W'(i);
         end
      end
   end

   always_comb begin
      cls = CLS_NONE;
      pin = '0;
      if (diff == '0) begin
         cls = CLS_NONE;
      end else if (|code_hit) begin
         cls = CLS_ADDR;
         pin = hit_idx;
      end else if (ndiff == NDIFF_W'(1)) begin
         cls = CLS_DATA;
         pin = bit_idx;
      end else if (ndiff == NDIFF_W'(2)) begin
         cls = CLS_DOUBLE;
      end else begin
         cls = CLS_UNEXPL;
      end
   end

endmodule

// File: rtl/bfc_counters.sv
module bfc_counters #(
   parameter int N     = 5,
   parameter int CNT_W = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      clr,
   input  logic [N-1:0]              inc,
   output logic [N-1:0][CNT_W-1:0]   cnt
);

   for (genvar g = 0; g < N; g++) begin : g_cnt
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst || clr) begin
            q <= '0;
         end else if (inc[g]) begin
            q <= q + CNT_W'(1);
         end
      end
      assign cnt[g] = q;
   end

endmodule

// File: rtl/bus_fault_probe.sv
module bus_fault_probe
   import bfc_pkg::*;
#(
   parameter int  ADDR_W = 22,
   parameter int  DATA_W = 8,
   parameter int  CNT_W  = 16,
   localparam int PIN_W  = (ADDR_W > 8) ? $clog2(ADDR_W) : 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              run_en,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [ADDR_W-1:0] res_addr,
   output logic [DATA_W-1:0] res_exp,
   output logic [DATA_W-1:0] res_act,
   output logic [2:0]        res_class,
   output logic [PIN_W-1:0]  res_pin,
   input  logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_data,
   output logic [CNT_W-1:0]  cnt_reads,
   output logic [CNT_W-1:0]  cnt_data,
   output logic [CNT_W-1:0]  cnt_addr,
   output logic [CNT_W-1:0]  cnt_double,
   output logic [CNT_W-1:0]  cnt_unexpl
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
   localparam logic [ADDR_W-1:0] BOT_ADDR = '0;

   if (ADDR_W < 3 || ADDR_W > BFC_MAX_ADDR_W) begin : g_bad_addr_w
      $error("bus_fault_probe: ADDR_W must lie in 3..22");
   end
   if (DATA_W != 8) begin : g_bad_data_w
      $error("bus_fault_probe: pin codes need an 8-bit data path");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("bus_fault_probe: CNT_W too small");
   end

   logic              phase_q;
   logic              busy_q;
   logic              req_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic              issue;
   logic              take;

   logic [DATA_W-1:0] fly_exp;
   bfc_class_e        fly_cls;
   logic [PIN_W-1:0]  fly_pin;

   logic              rv_q;
   logic [ADDR_W-1:0] ra_q;
   logic [DATA_W-1:0] re_q;
   logic [DATA_W-1:0] rx_q;
   bfc_class_e        rc_q;
   logic [PIN_W-1:0]  rp_q;

   logic [BFC_NUM_CNT-1:0]            cnt_inc;
   logic [BFC_NUM_CNT-1:0][CNT_W-1:0] cnt_all;

   assign issue = run_en && !busy_q && !rv_q && !start;
   assign take  = mem_rvalid && busy_q;

   // Read sequencer
   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q    <= 1'b0;
         busy_q     <= 1'b0;
         req_q      <= 1'b0;
         req_addr_q <= '0;
      end else begin
         req_q <= issue;
         if (issue) begin
            req_addr_q <= phase_q ? TOP_ADDR : BOT_ADDR;
            busy_q     <= 1'b1;
            phase_q    <= !phase_q;
         end else if (take) begin
            busy_q <= 1'b0;
         end
         if (start) begin
            phase_q <= 1'b0;
         end
      end
   end

   assign mem_req  = req_q;
   assign mem_addr = req_addr_q;

   // Expected byte for the read in flight, and for the lookup port
   bfc_expect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exp_fly (
      .addr (req_addr_q),
      .data (fly_exp)
   );

   bfc_expect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exp_look (
      .addr (q_addr),
      .data (q_data)
   );

   bfc_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W)) u_cls (
      .exp_byte (fly_exp),
      .act_byte (mem_rdata),
      .cls      (fly_cls),
      .pin      (fly_pin)
   );

   // Result holding register
   always_ff @(posedge clk) begin
      if (rst) begin
         rv_q <= 1'b0;
         ra_q <= '0;
         re_q <= '0;
         rx_q <= '0;
         rc_q <= CLS_NONE;
         rp_q <= '0;
      end else if (start) begin
         rv_q <= 1'b0;
      end else if (take && fly_cls != CLS_NONE) begin
         rv_q <= 1'b1;
         ra_q <= req_addr_q;
         re_q <= fly_exp;
         rx_q <= mem_rdata;
         rc_q <= fly_cls;
         rp_q <= fly_pin;
      end else if (rv_q && res_ready) begin
         rv_q <= 1'b0;
      end
   end

   assign res_valid = rv_q;
   assign res_addr  = ra_q;
   assign res_exp   = re_q;
   assign res_act   = rx_q;
   assign res_class = rc_q;
   assign res_pin   = rp_q;

   // Statistics
   assign cnt_inc[0] = take;
   assign cnt_inc[1] = take && (fly_cls == CLS_DATA);
   assign cnt_inc[2] = take && (fly_cls == CLS_ADDR);
   assign cnt_inc[3] = take && (fly_cls == CLS_DOUBLE);
   assign cnt_inc[4] = take && (fly_cls == CLS_UNEXPL);

   bfc_counters #(.N(BFC_NUM_CNT), .CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (start),
      .inc (cnt_inc),
      .cnt (cnt_all)
   );

   assign cnt_reads  = cnt_all[0];
   assign cnt_data   = cnt_all[1];
   assign cnt_addr   = cnt_all[2];
   assign cnt_double = cnt_all[3];
   assign cnt_unexpl = cnt_all[4];

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int PIN_W  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              res_valid,
   input logic              res_ready,
   input logic [ADDR_W-1:0] res_addr,
   input logic [DATA_W-1:0] res_exp,
   input logic [DATA_W-1:0] res_act,
   input logic [2:0]        res_class,
   input logic [PIN_W-1:0]  res_pin,
   input logic [ADDR_W-1:0] q_addr,
   input logic [DATA_W-1:0] q_data,
   input logic [CNT_W-1:0]  cnt_reads,
   input logic [CNT_W-1:0]  cnt_data,
   input logic [CNT_W-1:0]  cnt_addr,
   input logic [CNT_W-1:0]  cnt_double,
   input logic [CNT_W-1:0]  cnt_unexpl
);

   logic have_last;
   logic last_top;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         have_last <= 1'b0;
         last_top  <= 1'b0;
      end else if (mem_req) begin
         have_last <= 1'b1;
         last_top  <= mem_addr[0];
      end
   end

   assert_probe_map_R2: assert property (@(posedge clk) disable iff (rst)
      (q_addr == '0) |-> (q_data == '1));

   assert_req_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      mem_req |=> !mem_req);

   assert_probe_addr_R5: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> (mem_addr == '0 || mem_addr == '1));

   assert_first_bottom_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !have_last) |-> (mem_addr == '0));

   assert_alternate_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_req && have_last) |-> (mem_addr[0] != last_top));

   assert_no_req_waiting_R5: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> !mem_req);

   assert_err_only_R6: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (res_act != res_exp && res_class != 3'd0));

   assert_data_single_R7: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_class == 3'd1) |->
         ((res_act ^ res_exp) == (DATA_W'(1) << res_pin)));

   assert_double_two_R9: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_class == 3'd3) |-> ($countones(res_act ^ res_exp) == 2));

   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_ready && !start) |=>
         (res_valid && $stable(res_addr) && $stable(res_exp) && $stable(res_act)
          && $stable(res_class) && $stable(res_pin)));

   assert_cnt_step_R11: assert property (@(posedge clk) disable iff (rst)
      (mem_rvalid && !start) |=> (cnt_reads == CNT_W'($past(cnt_reads) + 1'b1)));

   assert_start_clear_R12: assert property (@(posedge clk) disable iff (rst)
      start |=> (cnt_reads == '0 && cnt_data == '0 && cnt_addr == '0
                 && cnt_double == '0 && cnt_unexpl == '0 && !res_valid));

endmodule

bind bus_fault_probe bfc_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .PIN_W  (PIN_W)
) u_bfc_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .res_valid  (res_valid),
   .res_ready  (res_ready),
   .res_addr   (res_addr),
   .res_exp    (res_exp),
   .res_act    (res_act),
   .res_class  (res_class),
   .res_pin    (res_pin),
   .q_addr     (q_addr),
   .q_data     (q_data),
   .cnt_reads  (cnt_reads),
   .cnt_data   (cnt_data),
   .cnt_addr   (cnt_addr),
   .cnt_double (cnt_double),
   .cnt_unexpl (cnt_unexpl)
);

// File: tb/bus_fault_probe_test.sv
`timescale 1ns/1ps
module bus_fault_probe_test;

   localparam int AW = 22;
   localparam int DW = 8;
   localparam int CW = 16;
   localparam int PW = 5;
   localparam logic [AW-1:0] TOPA = '1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          run_en = 1'b0;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          res_valid;
   logic          res_ready = 1'b0;
   logic [AW-1:0] res_addr;
   logic [DW-1:0] res_exp;
   logic [DW-1:0] res_act;
   logic [2:0]    res_class;
   logic [PW-1:0] res_pin;
   logic [AW-1:0] q_addr = '0;
   logic [DW-1:0] q_data;
   logic [CW-1:0] cnt_reads, cnt_data, cnt_addr, cnt_double, cnt_unexpl;

   bus_fault_probe uut (
      .clk(clk), .rst(rst), .start(start), .run_en(run_en),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .res_valid(res_valid), .res_ready(res_ready),
      .res_addr(res_addr), .res_exp(res_exp), .res_act(res_act),
      .res_class(res_class), .res_pin(res_pin),
      .q_addr(q_addr), .q_data(q_data),
      .cnt_reads(cnt_reads), .cnt_data(cnt_data), .cnt_addr(cnt_addr),
      .cnt_double(cnt_double), .cnt_unexpl(cnt_unexpl)
   );

   always #2 clk = ~clk;

   logic [7:0] codes [0:21] = '{8'h07, 8'h0B, 8'h0D, 8'h0E, 8'h16, 8'h1A, 8'h1C, 8'h1F,
                                8'h25, 8'h29, 8'h2C, 8'h2F, 8'h34, 8'h38, 8'h3D, 8'h3E,
                                8'h43, 8'h49, 8'h4A, 8'h4F, 8'h52, 8'h58};
   logic [7:0] ring [0:5] = '{8'h33, 8'h55, 8'h66, 8'h99, 8'hAA, 8'hCC};

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct packed {
      logic [AW-1:0] a;
      logic [7:0]    e;
      logic [7:0]    x;
      logic [2:0]    c;
      logic [PW-1:0] p;
   } rec_t;

   rec_t          rq[$];
   int            m_cnt[5] = '{0, 0, 0, 0, 0};
   bit            pend = 0;
   int            wait_n = 0;
   int            lat_sel = 0;
   logic [AW-1:0] pend_addr = '0;
   bit            exp_top = 0;
   logic [AW-1:0] f_amask = '0;
   logic [7:0]    f_dmask = '0;
   int            rdy_mode = 1;
   bit            do_start = 0;
   int            cyc = 0;

   function automatic logic [7:0] model_byte(input logic [AW-1:0] a);
      int n;
      n = $countones(a);
      if (n == 0) return 8'hFF;
      if (n == AW) return 8'h00;
      for (int k = 0; k < AW; k++) begin
         if (n == 1 && a[k]) return codes[k];
         if (n == AW - 1 && !a[k]) return codes[k];
      end
      return ring[n % 6];
   endfunction

   task automatic model_class(input logic [7:0] e, input logic [7:0] x,
                              output int c, output int p);
      int hit;
      logic [7:0] d;
      c = 0; p = 0; hit = -1;
      if (e == x) return;
      for (int k = AW - 1; k >= 0; k--) if (x == codes[k]) hit = k;
      d = e ^ x;
      if (hit >= 0) begin
         c = 2; p = hit;
      end else if ($countones(d) == 1) begin
         c = 1;
         for (int b = 0; b < 8; b++) if (d[b]) p = b;
      end else if ($countones(d) == 2) begin
         c = 3;
      end else begin
         c = 4;
      end
   endtask

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string cls_tag(input logic [2:0] c);
      case (c)
         3'd1: return "R7";
         3'd2: return "R8";
         default: return "R9";
      endcase
   endfunction

   // Per-clock comparison, memory responder and handshake driver
   always @(negedge clk) begin
      if (!rst) begin
         int c, p;
         logic [7:0] e, x;
         cyc++;
         check("R11", cnt_reads,  m_cnt[0], "read count");
         check("R11", cnt_data,   m_cnt[1], "data count");
         check("R11", cnt_addr,   m_cnt[2], "addr count");
         check("R11", cnt_double, m_cnt[3], "double count");
         check("R11", cnt_unexpl, m_cnt[4], "unexplained count");
         if (res_valid) begin
            if (rq.size() == 0) begin
               check("R6", 1, 0, "result without fault");
            end else begin
               check("R10", res_addr, rq[0].a, "result address");
               check("R10", res_exp,  rq[0].e, "result expected byte");
               check("R10", res_act,  rq[0].x, "result actual byte");
               check(cls_tag(rq[0].c), res_class, rq[0].c, "result class");
               check(cls_tag(rq[0].c), res_pin,   rq[0].p, "result pin");
            end
            check("R5", mem_req, 0, "request while result waits");
         end
         start = 1'b0;
         if (do_start && !pend && !mem_req) begin
            start = 1'b1;
            do_start = 0;
            for (int i = 0; i < 5; i++) m_cnt[i] = 0;
            rq.delete();
            exp_top = 0;
         end
         case (rdy_mode)
            0: res_ready = 1'b0;
            1: res_ready = 1'b1;
            default: res_ready = (cyc % 3) != 0;
         endcase
         if (res_valid && res_ready && rq.size() > 0) void'(rq.pop_front());
         if (mem_req) begin
            check("R5", pend, 0, "second outstanding read");
            check("R5", mem_addr, exp_top ? TOPA : '0, "probe order");
            exp_top = !exp_top;
            pend = 1;
            wait_n = lat_sel % 3;
            lat_sel++;
            pend_addr = mem_addr;
         end
         mem_rvalid = 1'b0;
         if (pend) begin
            if (wait_n == 0) begin
               e = model_byte(pend_addr);
               x = model_byte(pend_addr ^ f_amask) ^ f_dmask;
               mem_rdata = x;
               mem_rvalid = 1'b1;
               pend = 0;
               model_class(e, x, c, p);
               m_cnt[0]++;
               if (c != 0) begin
                  m_cnt[c]++;
                  rq.push_back('{a: pend_addr, e: e, x: x, c: 3'(c), p: PW'(p)});
               end
            end else begin
               wait_n--;
            end
         end
      end
   end

   task automatic map_check(input logic [AW-1:0] a, input string req);
      q_addr = a;
      #1;
      check(req, q_data, model_byte(a), "lookup byte");
   endtask

   task automatic run_reads(input int n);
      int tgt;
      tgt = m_cnt[0] + n;
      run_en = 1'b1;
      while (m_cnt[0] < tgt) @(negedge clk);
      run_en = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [AW-1:0] lf;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", mem_req, 0, "request after reset");
      check("R1", res_valid, 0, "result after reset");
      check("R1", cnt_reads, 0, "read count after reset");

      // Expected-byte map
      map_check('0, "R2");
      check("R2", q_data, 8'hFF, "bottom probe byte");
      map_check(TOPA, "R2");
      check("R2", q_data, 8'h00, "top probe byte");
      for (int k = 0; k < AW; k++) begin
         map_check(AW'(1) << k, "R3");
         map_check(TOPA ^ (AW'(1) << k), "R3");
      end
      for (int n = 2; n <= AW - 2; n++) map_check((AW'(1) << n) - AW'(1), "R4");
      lf = 22'h2A5C31;
      for (int i = 0; i < 80; i++) begin
         lf = {lf[AW-2:0], lf[21] ^ lf[20]};
         map_check(lf, "R4");
      end
      @(negedge clk);

      // Clean memory: alternation, no results (R5, R6, R11)
      rdy_mode = 1;
      run_reads(20);
      // Single data line, every bit (R7)
      for (int b = 0; b < 8; b++) begin
         f_dmask = 8'(1 << b);
         run_reads(4);
      end
      f_dmask = '0;
      // Address line, every pin from both probes (R8)
      for (int k = 0; k < AW; k++) begin
         f_amask = AW'(1) << k;
         run_reads(2);
      end
      f_amask = '0;
      // Two-bit and wider mismatches (R9), one that forms a pin code (R8)
      f_dmask = 8'h03; run_reads(4);
      f_dmask = 8'h81; run_reads(4);
      f_dmask = 8'h07; run_reads(4);
      f_dmask = 8'hF0; run_reads(4);
      // Back-pressure on results (R10)
      rdy_mode = 2;
      f_dmask = 8'h10; run_reads(10);
      // Start while a result waits (R12)
      rdy_mode = 0;
      f_dmask = 8'h40;
      run_reads(1);
      check("R10", res_valid, 1, "result held without ready");
      do_start = 1;
      wait (do_start == 0);
      @(negedge clk);
      check("R12", res_valid, 0, "result after start");
      check("R12", cnt_reads, 0, "read count after start");
      check("R12", cnt_data, 0, "data count after start");
      rdy_mode = 1;
      f_dmask = '0;
      run_reads(5);
      finish_run();
   end

endmodule